// File: doc/BRIEF.md
# Serial-to-Parallel Pixel Word Deserializer

This block turns four serial lanes from a display link into parallel pixel words. Three lanes carry data and one carries a framing pattern. Each lane delivers seven bit slots in every pixel period. The block runs on a sampling clock at seven times the pixel rate, and that clock is phase-aligned to the incoming framing lane, so each rising edge captures exactly one slot on every lane. The block finds the word boundary in the framing-lane pattern. It then rebuilds a 21-bit word made of three 6-bit colour channels, a line sync bit, a frame sync bit and a data-enable bit.

The rebuilt word is presented with a pixel clock that the block generates. New data appears together with the rising edge of that clock and stays constant through its falling edge, which is the data strobe. The block counts consecutive correctly framed words, and it releases data only once that count reaches a programmable threshold. An active-low power-down input holds every data output low.

Top module: `lvds_pixel_deser`

## Requirements
- R1: Each word period holds seven slots per lane. Slot 0 is the first sample taken after the framing lane goes from low to high. A correctly framed word shows the framing lane high in slots 0 to 3 and low in slots 4 to 6. Slot s of data lane l becomes bit l*7+s of the 21-bit word.
- R2: Word bits 5:0 drive `red`, bits 11:6 drive `green`, bits 17:12 drive `blue`, bit 18 drives `line_sync`, bit 19 drives `frame_sync` and bit 20 drives `data_en`.
- R3: A word appears on the outputs at the sampling edge one sample period after its slot 6 was sampled. At that same edge `pix_clk` goes high. The outputs then hold for seven sample periods unless R6 or R8 applies.
- R4: `pix_clk` is high for four sample periods and low for three. The data outputs do not change at the edge where `pix_clk` falls.
- R5: `locked` is high exactly when the number of consecutive correctly framed words is at least `lock_words`. A `lock_words` value of 0 acts as 1. A captured word reaches the outputs only while locked. Otherwise the outputs are driven low.
- R6: If a correctly framed word is missing at the expected boundary, the consecutive count returns to zero. At that boundary `locked` drops and the data outputs go low.
- R7: If the framing pattern appears at a different slot phase, the block realigns to it and restarts the consecutive count at one. After that it locks again once the count reaches `lock_words`.
- R8: When `pwr_dn_n` is low at a sampling edge, all 21 data outputs are low after that edge. Framing and lock tracking continue during power-down. After release, the next captured word is shown.
- R9: A synchronous active-high reset drives all data outputs low and `locked` low, sets `pix_clk` high, and clears the consecutive count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock at seven times the pixel rate, phase-aligned to the framing lane |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Active-low power-down; low forces all data outputs low |
| lock_words | input | LCW (4) | Consecutive framed words needed for lock |
| lane_d | input | 3 | Serial data lanes, one slot per `clk` |
| lane_ck | input | 1 | Serial framing lane |
| pix_clk | output | 1 | Recovered pixel clock; falling edge is the data strobe |
| red | output | 6 | Red channel |
| green | output | 6 | Green channel |
| blue | output | 6 | Blue channel |
| line_sync | output | 1 | Line sync bit |
| frame_sync | output | 1 | Frame sync bit |
| data_en | output | 1 | Data-enable bit |
| locked | output | 1 | Framing lock indication |

## Verification
The assertions rely on the following assumptions about the inputs:
- `lock_words` changes only while reset is held. A change in the middle of a stream could move `locked` without any framing event.
- `pwr_dn_n` is synchronous to the sampling clock.
- Every `clk` edge sees exactly one slot per lane.

The stimulus follows these rules. Inputs are driven only at falling edges of `clk`. `lock_words` is reloaded under reset. Phase slips are made by inserting whole idle slots, so the framing lane never shows a partial slot. Corrupted words keep the framing lane high for the whole period, so no false pattern can form across word boundaries.

// File: rtl/pxdes_pkg.sv
package pxdes_pkg;

    localparam int SLOTS   = 7;
    localparam int LANES   = 3;
    localparam int CK_HIGH = 4;
    localparam int COLOR_W = 6;
    localparam int WORD_W  = LANES * SLOTS;

    typedef logic [SLOTS-1:0] slot_vec_t;

    typedef struct packed {
        logic               de;
        logic               fsync;
        logic               lsync;
        logic [COLOR_W-1:0] blu;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] red;
    } pix_word_t;

    // Position of a lane slot inside the parallel word
    function automatic int unsigned word_bit(int unsigned lane, int unsigned slot);
        return lane * SLOTS + slot;
    endfunction

    // Framing-lane history of a correctly framed word, index = slot
    function automatic slot_vec_t frame_pattern();
        slot_vec_t p;
        for (int s = 0; s < SLOTS; s++) begin
            p[s] = (s < CK_HIGH);
        end
        return p;
    endfunction

endpackage

// File: rtl/pxdes_lane_shift.sv
module pxdes_lane_shift
    import pxdes_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output slot_vec_t hist
);

    // Oldest sample at index 0, newest at the top
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {din, hist[SLOTS-1:1]};
        end
    end

endmodule

// File: rtl/pxdes_frame_track.sv
module pxdes_frame_track
    import pxdes_pkg::*;
#(
    parameter int LCW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  slot_vec_t      ck_hist,
    input  logic [LCW-1:0] lock_words,
    output logic           capture,
    output logic           miss,
    output logic           lock_next,
    output logic           locked
);

    localparam slot_vec_t          PAT     = frame_pattern();
    localparam int                 PH_W    = $clog2(SLOTS);
    localparam logic [PH_W-1:0]    PH_LAST = PH_W'(SLOTS - 1);

    logic [PH_W-1:0] ph;
    logic [LCW-1:0]  streak;
    logic [LCW-1:0]  streak_nx;
    logic [LCW-1:0]  lock_min;
    logic            at_bound;

    assign at_bound = (ph == PH_LAST);
    assign capture  = (ck_hist == PAT);
    assign miss     = at_bound && !capture;
    assign lock_min = (lock_words == '0) ? LCW'(1) : lock_words;

    always_comb begin
        streak_nx = streak;
        if (capture) begin
            if (!at_bound) begin
                streak_nx = LCW'(1);              // realign
            end else if (!(&streak)) begin
                streak_nx = streak + 1'b1;
            end
        end else if (miss) begin
            streak_nx = '0;
        end
    end

    assign lock_next = (streak_nx >= lock_min);
    assign locked    = (streak >= lock_min);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= '0;
            streak <= '0;
        end else begin
            ph     <= (capture || at_bound) ? '0 : ph + 1'b1;
            streak <= streak_nx;
        end
    end

    // R6: a missing frame at the boundary removes lock
    assert_miss_unlocks_R6: assert property (@(posedge clk) disable iff (rst)
        miss |=> !locked);

    // R7: realignment restarts the count, so a threshold above one is not met
    assert_realign_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (capture && !at_bound && (lock_min > LCW'(1))) |=> !locked);

endmodule

// File: rtl/pxdes_word_build.sv
module pxdes_word_build
    import pxdes_pkg::*;
(
    input  slot_vec_t [LANES-1:0] d_hist,
    output pix_word_t             word
);

    logic [WORD_W-1:0] flat;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign flat[word_bit(l, s)] = d_hist[l][s];
        end
    end

    assign word = pix_word_t'(flat);

endmodule

// File: rtl/pxdes_pixel_out.sv
module pxdes_pixel_out
    import pxdes_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_n,
    input  logic      capture,
    input  logic      miss,
    input  logic      lock_next,
    input  logic      locked,
    input  pix_word_t word_in,
    output pix_word_t word_out,
    output logic      pix_clk
);

    localparam int              PH_W    = $clog2(SLOTS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOTS - 1);
    localparam logic [PH_W-1:0] PH_FALL = PH_W'(CK_HIGH);

    logic [PH_W-1:0] oph;
    logic [PH_W-1:0] oph_nx;

    always_comb begin
        if (capture || oph == PH_LAST) begin
            oph_nx = '0;
        end else begin
            oph_nx = oph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oph     <= '0;
            pix_clk <= 1'b1;
        end else begin
            oph     <= oph_nx;
            pix_clk <= (oph_nx < PH_FALL);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_n) begin
            word_out <= '0;
        end else if (capture) begin
            word_out <= lock_next ? word_in : '0;
        end else if (miss) begin
            word_out <= '0;
        end
    end

    // R8: power-down clears all data outputs
    assert_pd_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !pwr_n |=> (word_out == '0));

    // R5: data reaches the outputs only under lock
    assert_lock_gates_R5: assert property (@(posedge clk) disable iff (rst)
        (word_out != '0) |-> locked);

    // R3: a captured word comes with a rising pixel clock
    assert_rise_on_capture_R3: assert property (@(posedge clk) disable iff (rst)
        capture |=> pix_clk);

    // R4: data holds across the strobe edge
    assert_strobe_stable_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(pix_clk) && $past(pwr_n)) |-> $stable(word_out));

endmodule

// File: rtl/lvds_pixel_deser.sv
module lvds_pixel_deser
    import pxdes_pkg::*;
#(
    parameter int LCW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_dn_n,
    input  logic [LCW-1:0]     lock_words,
    input  logic [LANES-1:0]   lane_d,
    input  logic               lane_ck,
    output logic               pix_clk,
    output logic [COLOR_W-1:0] red,
    output logic [COLOR_W-1:0] green,
    output logic [COLOR_W-1:0] blue,
    output logic               line_sync,
    output logic               frame_sync,
    output logic               data_en,
    output logic               locked
);

    localparam int NSER = LANES + 1;   // data lanes plus framing lane

    logic [NSER-1:0]       ser_in;
    slot_vec_t [NSER-1:0]  hist_all;
    slot_vec_t [LANES-1:0] d_hist;
    logic                  capture;
    logic                  miss;
    logic                  lock_next;
    pix_word_t             word_bus;
    pix_word_t             word_out;

    assign ser_in = {lane_ck, lane_d};

    for (genvar i = 0; i < NSER; i++) begin : g_shift
        pxdes_lane_shift u_shift (
            .clk  (clk),
            .rst  (rst),
            .din  (ser_in[i]),
            .hist (hist_all[i])
        );
    end

    assign d_hist = hist_all[LANES-1:0];

    pxdes_frame_track #(.LCW(LCW)) u_track (
        .clk        (clk),
        .rst        (rst),
        .ck_hist    (hist_all[LANES]),
        .lock_words (lock_words),
        .capture    (capture),
        .miss       (miss),
        .lock_next  (lock_next),
        .locked     (locked)
    );

    pxdes_word_build u_build (
        .d_hist (d_hist),
        .word   (word_bus)
    );

    pxdes_pixel_out u_out (
        .clk       (clk),
        .rst       (rst),
        .pwr_n     (pwr_dn_n),
        .capture   (capture),
        .miss      (miss),
        .lock_next (lock_next),
        .locked    (locked),
        .word_in   (word_bus),
        .word_out  (word_out),
        .pix_clk   (pix_clk)
    );

    assign red        = word_out.red;
    assign green      = word_out.grn;
    assign blue       = word_out.blu;
    assign line_sync  = word_out.lsync;
    assign frame_sync = word_out.fsync;
    assign data_en    = word_out.de;

endmodule

// File: tb/sim_lvds_pixel_deser.sv
module sim_lvds_pixel_deser;
    import pxdes_pkg::*;

    localparam int LCW  = 4;
    localparam int NVEC = 11;
    localparam int SMAX = (1 << LCW) - 1;

    // {power on, framing ok, word}
    localparam logic [WORD_W+1:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 21'h015555},
        {1'b1, 1'b1, 21'h00AAAA},
        {1'b1, 1'b1, 21'h1FFFFF},
        {1'b1, 1'b1, 21'h000001},
        {1'b1, 1'b1, 21'h100000},
        {1'b0, 1'b1, 21'h0F0F0F},
        {1'b1, 1'b1, 21'h070707},
        {1'b1, 1'b0, 21'h1ABCDE},
        {1'b1, 1'b1, 21'h054321},
        {1'b1, 1'b1, 21'h123456},
        {1'b1, 1'b1, 21'h0FEDCB}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pwr_dn_n = 1'b1;
    logic [LCW-1:0]     lock_words = LCW'(3);
    logic [LANES-1:0]   lane_d = '0;
    logic               lane_ck = 1'b0;
    logic               pix_clk;
    logic [COLOR_W-1:0] red, green, blue;
    logic               line_sync, frame_sync, data_en, locked;
    logic [WORD_W-1:0]  got;

    int                checks = 0;
    int                errors = 0;
    int                streak_m = 0;
    bit                prev_valid = 0;
    bit                post_slip = 0;
    bit                done = 0;
    logic [WORD_W-1:0] prev_word = '0;

    always #2.5ns clk = ~clk;

    lvds_pixel_deser #(.LCW(LCW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .pwr_dn_n   (pwr_dn_n),
        .lock_words (lock_words),
        .lane_d     (lane_d),
        .lane_ck    (lane_ck),
        .pix_clk    (pix_clk),
        .red        (red),
        .green      (green),
        .blue       (blue),
        .line_sync  (line_sync),
        .frame_sync (frame_sync),
        .data_en    (data_en),
        .locked     (locked)
    );

    assign got = {data_en, frame_sync, line_sync, blue, green, red};

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit lock_m();
        int n = (lock_words == '0) ? 1 : int'(lock_words);
        return streak_m >= n;
    endfunction

    task automatic check_prev(int s, string tag);
        logic [WORD_W-1:0] exp;
        if (s == 0 && post_slip) begin
            chk("R6 R7", 32'(got), 32'h0, "word after missed boundary");
            chk("R6 R7", 32'(locked), 32'h0, "locked after missed boundary");
            post_slip = 0;
        end
        if (!prev_valid) return;
        exp = (pwr_dn_n && lock_m()) ? prev_word : '0;
        if (s == 1) begin
            chk({"R1 R2 R3 ", tag}, 32'(got), 32'(exp), "word");
            chk({"R5 ", tag}, 32'(locked), 32'(lock_m()), "locked");
            chk("R3 R4", 32'(pix_clk), 32'h1, "pix_clk rise");
        end else if (s == 4) begin
            chk("R4", 32'(pix_clk), 32'h1, "pix_clk fourth high slot");
        end else if (s == 5) begin
            chk("R4", 32'(pix_clk), 32'h0, "pix_clk low");
            chk({"R4 ", tag}, 32'(got), 32'(exp), "word at strobe");
        end
    endtask

    task automatic send_word(logic [WORD_W-1:0] w, bit ck_ok, bit pwr, string tag);
        for (int s = 0; s < SLOTS; s++) begin
            @(negedge clk);
            check_prev(s, tag);
            if (s == 0) pwr_dn_n = pwr;
            lane_ck = ck_ok ? (s < CK_HIGH) : 1'b1;
            for (int l = 0; l < LANES; l++) begin
                lane_d[l] = w[l*SLOTS + s];
            end
        end
        if (ck_ok) streak_m = (streak_m >= SMAX) ? SMAX : streak_m + 1;
        else       streak_m = 0;
        prev_word  = w;
        prev_valid = 1;
    endtask

    task automatic slip_slots();
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check_prev(s, "R7");
            lane_ck = 1'b0;
            lane_d  = '0;
        end
        prev_valid = 0;
        streak_m   = 0;
    endtask

    task automatic do_reset(logic [LCW-1:0] lw);
        @(negedge clk);
        rst     = 1'b1;
        lane_ck = 1'b0;
        lane_d  = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R9", 32'(got), 32'h0, "word in reset");
        chk("R9", 32'(locked), 32'h0, "locked in reset");
        chk("R9", 32'(pix_clk), 32'h1, "pix_clk in reset");
        lock_words = lw;
        rst        = 1'b0;
        streak_m   = 0;
        prev_valid = 0;
        post_slip  = 0;
    endtask

    initial begin
        do_reset(LCW'(3));

        // Table walk: lock-up, patterns, power-down, corrupted framing
        for (int i = 0; i < NVEC; i++) begin
            send_word(VEC[i][WORD_W-1:0], VEC[i][WORD_W], VEC[i][WORD_W+1], "R6 R8");
        end

        // Phase slip and realignment
        slip_slots();
        send_word(21'h02468A, 1'b1, 1'b1, "R7");
        post_slip = 1;
        send_word(21'h13579B, 1'b1, 1'b1, "R7");
        send_word(21'h0C0FFE, 1'b1, 1'b1, "R7");
        send_word(21'h1E1E1E, 1'b1, 1'b1, "R7");
        send_word(21'h000000, 1'b1, 1'b1, "R7");

        // Zero threshold behaves as one
        do_reset(LCW'(0));
        send_word(21'h0ABCDE, 1'b1, 1'b1, "R5");
        send_word(21'h155AA5, 1'b1, 1'b1, "R5");
        send_word(21'h040201, 1'b1, 1'b1, "R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule